// File: doc/BRIEF.md
# Chunk-Counted Stream Buffer with End-of-Frame Drain

This block is a synchronous word buffer between a producer of 64-bit words and a reader that moves data in bursts of four words. The reader never sees a word count. It sees how many whole four-word chunks (32 bytes) it can take, so a burst engine can start a transfer only when a full chunk is ready.

At the end of a frame the producer pulses an end-of-frame input. A trailing partial chunk is then rounded up to a whole chunk by advancing the write pointer, and a drain indication is raised. The drain indication stays high until the reader has consumed every chunk up to that rounded point. A discard input drops all unread data at once. It moves the read pointer onto the write pointer, which is first rounded up to a chunk boundary. Read data arrives two clocks after a read request.

Top module: `chunk_fifo`

## Requirements
- R1: After reset, `chunk_count` is 0, `drain` is 0 and `overflow` is 0.
- R2: `chunk_count` rises by one in the cycle after the fourth word of a chunk is written. The first three words of a chunk leave it unchanged.
- R3: `chunk_count` falls by one in the cycle after the fourth word of a chunk is read. Reading the first three words of a chunk leaves it unchanged.
- R4: Words come out in write order. A word requested by `rd_en` at rising edge k appears on `rd_data` after edge k+1, and `rd_data` holds that value until a later read replaces it.
- R5: `rd_en` while no word is stored is ignored. The read position, the count and `rd_data` stay unchanged.
- R6: A `frame_end` pulse with a partial chunk stored rounds that chunk up, so `chunk_count` becomes the number of written words divided by four, rounded up. The padding words are read like data, and their contents are unspecified.
- R7: A `frame_end` pulse with data stored sets `drain` in the next cycle. `drain` stays high until the read that consumes the last word of the rounded-up frame, and it is low in the cycle after that read.
- R8: A `frame_end` pulse with nothing stored and the write position on a chunk boundary leaves `drain` low.
- R9: `discard` sets `chunk_count`, `drain` and `overflow` to 0 in the next cycle. Data written before the discard is never read out, and data written after it is read first.
- R10: A write while the buffer is full is dropped and sets `overflow`. `overflow` stays set until the next `discard` or reset.
- R11: Space is freed one whole chunk at a time. The buffer is full when DEPTH_CHUNKS chunks are held, counting a partly read chunk, so a write after only 1 to 3 words of a full buffer have been read is still dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one word |
| wr_data | input | DATA_W | Word to write |
| frame_end | input | 1 | End of frame: pad to a chunk boundary and start drain |
| discard | input | 1 | Drop all unread data |
| rd_en | input | 1 | Read one word |
| rd_data | output | DATA_W | Read word, two clocks after the request |
| chunk_count | output | COUNT_W | Whole or partly read chunks held |
| drain | output | 1 | Frame end pending until its chunks are read |
| overflow | output | 1 | Sticky: a write was dropped while full |

## Verification
Frame sizes from zero to the full capacity are each written and then closed with `frame_end`. This separates correct rounding at every remainder modulo four from an off-by-one at chunk edges. It also covers the empty-frame case, where `drain` must stay low. Every frame is read back one word at a time. At each step the count and `drain` are compared with the word-index arithmetic, which checks both the chunk-granular decrement and the exact read that releases `drain`. A fill past capacity, followed by partial reads and further writes, shows that space is freed only whole chunks at a time and that `overflow` is sticky. Discards issued mid-frame and while `drain` is pending show that stale data is dropped.

// File: rtl/chunk_fifo.sv
module chunk_fifo #(
  parameter int DATA_W       = 64,
  parameter int DEPTH_CHUNKS = 16,
  parameter int COUNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_end,
  input  logic              discard,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [COUNT_W-1:0] chunk_count,
  output logic              drain,
  output logic              overflow
);
  localparam int DEPTH = DEPTH_CHUNKS * 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = AW + 1;
  localparam int CPW   = PW - 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr, tgt;
  logic [DATA_W-1:0] s1_d;
  logic s1_v;

  wire [PW-1:0] rfloor = {rptr[PW-1:2], 2'b00};
  wire full   = (wptr - rfloor) == PW'(DEPTH);
  wire empty  = rptr == wptr;
  wire do_wr  = wr_en && !full && !discard;
  wire do_rd  = rd_en && !empty && !discard;
  wire do_end = frame_end && !discard;

  wire [PW-1:0] wp_inc  = wptr + PW'(do_wr);
  wire [PW-1:0] wp_ceil = (wp_inc[1:0] == 2'b00) ? wp_inc : {wp_inc[PW-1:2] + 1'b1, 2'b00};
  wire [PW-1:0] w_align = (wptr[1:0] == 2'b00) ? wptr : {wptr[PW-1:2] + 1'b1, 2'b00};
  wire [PW-1:0] rp_next = rptr + PW'(do_rd);
  wire [CPW-1:0] chunks = wptr[PW-1:2] - rptr[PW-1:2];

  assign chunk_count = COUNT_W'(chunks);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      tgt <= '0;
      drain <= 1'b0;
      overflow <= 1'b0;
    end else if (discard) begin
      wptr <= w_align;
      rptr <= w_align;
      drain <= 1'b0;
      overflow <= 1'b0;
    end else begin
      wptr <= do_end ? wp_ceil : wp_inc;
      rptr <= rp_next;
      if (wr_en && full) overflow <= 1'b1;
      if (do_end) begin
        tgt <= wp_ceil;
        drain <= wp_ceil != rp_next;
      end else if (drain && rp_next == tgt) begin
        drain <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_d <= '0;
      rd_data <= '0;
    end else begin
      s1_v <= do_rd;
      if (do_rd) s1_d <= mem[rptr[AW-1:0]];
      if (s1_v) rd_data <= s1_d;
    end
  end

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_count <= COUNT_W'(DEPTH_CHUNKS));
  p_discard_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> (chunk_count == '0) && !drain && !overflow);
  p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !discard |=> overflow);
  p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && full && !discard |=> overflow && wptr == $past(wptr));
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && empty && !discard |=> rptr == $past(rptr));
  p_drain_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> chunk_count != '0);
endmodule

// File: tb/chunk_fifo_bench.sv
module chunk_fifo_bench;
  localparam int DW = 64;
  localparam int NCH = 4;
  localparam int NW = NCH * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, frame_end = 1'b0, discard = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [7:0] chunk_count;
  logic drain, overflow;

  int n_pass = 0, n_tot = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chunk_fifo #(.DATA_W(DW), .DEPTH_CHUNKS(NCH), .COUNT_W(8)) u_chunk_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .frame_end(frame_end), .discard(discard), .rd_en(rd_en),
    .rd_data(rd_data), .chunk_count(chunk_count), .drain(drain), .overflow(overflow));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tot++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic put(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  task automatic pulse_discard();
    discard = 1'b1; tick(); discard = 1'b0;
  endtask

  task automatic get(output logic [DW-1:0] d);
    rd_en = 1'b1; tick(); rd_en = 1'b0; tick(); d = rd_data;
  endtask

  function automatic logic [DW-1:0] pat(input int n, input int i);
    return 64'hA5C3_0000_0000_0000 ^ 64'(n * 256 + i);
  endfunction

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_pass, n_tot);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tot++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    wrap_up();
  end

  initial begin
    logic [DW-1:0] d, last;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(chunk_count == 0, "R1 count", chunk_count, 0);
    chk(drain == 0, "R1 drain", drain, 0);
    chk(overflow == 0, "R1 overflow", overflow, 0);

    last = '0;
    for (int n = 0; n <= NW; n++) begin
      int ceilc;
      pulse_discard();
      chk(chunk_count == 0, "R9 count after discard", chunk_count, 0);
      for (int i = 0; i < n; i++) begin
        put(pat(n, i));
        chk(chunk_count == 8'((i + 1) / 4), "R2 count on write", chunk_count, (i + 1) / 4);
      end
      ceilc = (n + 3) / 4;
      frame_end = 1'b1; tick(); frame_end = 1'b0;
      chk(chunk_count == 8'(ceilc), "R6 rounded count", chunk_count, ceilc);
      if (n == 0) chk(drain == 0, "R8 empty frame no drain", drain, 0);
      else chk(drain == 1, "R7 drain set", drain, 1);
      for (int i = 0; i < ceilc * 4; i++) begin
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        if (i > 0 && i <= n) chk(rd_data == last, "R4 not before two clocks", rd_data, last);
        chk(chunk_count == 8'(ceilc - (i + 1) / 4), "R3 count on read", chunk_count, ceilc - (i + 1) / 4);
        chk(drain == (i + 1 < ceilc * 4), "R7 drain hold/release", drain, (i + 1 < ceilc * 4));
        tick();
        if (i < n) begin
          chk(rd_data == pat(n, i), "R4 data order", rd_data, pat(n, i));
          last = rd_data;
        end
      end
      if (n == 5) begin
        last = rd_data;
        rd_en = 1'b1; tick(); tick(); tick(); rd_en = 1'b0;
        chk(chunk_count == 0, "R5 empty read count", chunk_count, 0);
        chk(rd_data == last, "R5 empty read data", rd_data, last);
        put(pat(99, 0));
        get(d);
        chk(d == pat(99, 0), "R5 pointer not moved", d, pat(99, 0));
        last = d;
      end
    end

    pulse_discard();
    for (int k = 0; k < NW + 4; k++) begin
      put(64'(1000 + k));
      chk(overflow == (k >= NW), "R10 overflow on full", overflow, (k >= NW));
    end
    chk(chunk_count == NCH, "R10 count at full", chunk_count, NCH);
    for (int k = 0; k < 3; k++) begin
      get(d);
      chk(d == 64'(1000 + k), "R11 data", d, 1000 + k);
    end
    put(64'd5555);
    chk(chunk_count == NCH, "R11 partial read frees nothing", chunk_count, NCH);
    chk(overflow == 1, "R10 sticky", overflow, 1);
    get(d);
    chk(d == 64'd1003, "R11 data", d, 1003);
    chk(chunk_count == NCH - 1, "R3 chunk freed", chunk_count, NCH - 1);
    for (int k = 0; k < 4; k++) put(64'(2000 + k));
    chk(chunk_count == NCH, "R11 refill", chunk_count, NCH);
    for (int k = 4; k < NW + 4; k++) begin
      logic [DW-1:0] e;
      e = (k < NW) ? 64'(1000 + k) : 64'(2000 + k - NW);
      get(d);
      chk(d == e, "R11 order after refill", d, e);
    end
    chk(overflow == 1, "R10 sticky after drain", overflow, 1);

    for (int k = 0; k < 6; k++) put(64'(3000 + k));
    frame_end = 1'b1; tick(); frame_end = 1'b0;
    chk(drain == 1, "R7 drain before discard", drain, 1);
    pulse_discard();
    chk(chunk_count == 0, "R9 count", chunk_count, 0);
    chk(drain == 0, "R9 drain", drain, 0);
    chk(overflow == 0, "R9 overflow", overflow, 0);
    for (int k = 0; k < 4; k++) put(64'(4000 + k));
    chk(chunk_count == 1, "R9 new chunk", chunk_count, 1);
    for (int k = 0; k < 4; k++) begin
      get(d);
      chk(d == 64'(4000 + k), "R9 stale data dropped", d, 4000 + k);
    end

    put(64'd7); put(64'd8);
    pulse_discard();
    for (int k = 0; k < 4; k++) put(64'(5000 + k));
    chk(chunk_count == 1, "R9 discard mid-chunk aligns", chunk_count, 1);
    get(d);
    chk(d == 64'd5000, "R9 first word after mid-chunk discard", d, 5000);

    wrap_up();
  end
endmodule